// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the register set of a single-root I/O virtualization extended capability placed inside a physical function's configuration space. A configuration access port presents dword addresses, a read/write flag, byte enables and write data. Accesses that land inside a sixteen-dword window starting at `CAP_BASE` are decoded. Each writable field is updated through a write mask, and some of these masks move at run time with the state of the capability.

The rest of the function reads two registered results: the count of virtual functions currently live, and the page size selected by software. The fixed fields are elaboration parameters: the identity counts, the routing offset and stride, the VF device identifier, the optional page sizes and the six VF BAR types and aperture sizes. Read data returns one cycle after the read is accepted.

Top module: `vfcap_regfile`

## Requirements
- R1: An access whose dword address is below `CAP_BASE` or at or above `CAP_BASE+16` is ignored: no register changes, and `rd_data` reads zero in the following cycle. An in-window read returns its dword on `rd_data` one cycle later. `rd_data` is zero in every other cycle.
- R2: A write changes only the bytes whose enable is set: enable bit k selects bits 8k+7..8k. The new value of each bit is the old value where the mask is clear and the written bit where the mask is set.
- R3: The control word sits in bits 15:0 of window dword 2. In it, bit 0 is VF enable, bit 3 is memory-space enable and bit 4 is the ARI hierarchy bit. Bits 3 and 4 are always writable. Bit 0 is writable after reset. After any write that enables byte 0 or byte 1 of dword 4, bit 0 is writable only if the resulting VF count is at most `TOTAL_VFS`.
- R4: A write to dword 2 with byte 0 enabled and data bit 0 set makes the VF count read-only. The same write with data bit 0 clear makes it writable again. Writes that enable only other bytes leave this lock unchanged.
- R5: `active_vfs` equals the VF count while VF enable is set and zero otherwise. It follows the registers with one cycle of delay.
- R6: The supported-page-size dword (dword 7) reads 0x553 ORed with `OPT_PGSZ`. The selected-page-size dword (dword 8) resets to 1, is writable exactly in the supported bits and drives `sys_page_size`.
- R7: The VF BAR dwords are 9 to 14 (BAR j at 9+j). The writable mask of a BAR is the inverse of (aperture size − 1). A memory BAR whose type bits 2:1 are 2'b10 is 64 bits wide: its upper 32 mask bits belong to the next dword, which resets to zero. Every other BAR resets to its type bits. Aperture sizes must be zero or a power of two.
- R8: Reset clears control, the VF count and the lock. Dword 3 reads {`TOTAL_VFS`,`INITIAL_VFS`}, dword 4 reads the VF count in bits 15:0, dword 5 reads {`VF_STRIDE`,`VF_OFFSET`} and dword 6 reads {`VF_DEVID`,16'h0}. The only writable fields are those of R3, R4, R6 and R7.
- R9: Dword 0 reads {`NEXT_PTR`,4'h1,16'h0010}. Dwords 1 and 15 and all unlisted bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Configuration-space dword address |
| acc_be | input | 4 | Byte enables for a write |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| active_vfs | output | 16 | Number of live virtual functions |
| sys_page_size | output | 32 | Selected page size bit vector |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges. They also assume one access per cycle, with all access inputs stable across the sampling edge. The bench keeps to this by driving every input at the falling edge and by leaving an idle cycle between accesses. The elaboration check assumes that the BAR aperture parameters are zero or a power of two. The default set meets this with a 64-bit BAR, a 32-bit BAR, an I/O BAR and unused slots. The lock and enable-gating sequences are run in orders that expose history dependence, such as locking while enable cannot be written.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;
  localparam int CAP_DWORDS = 16;
  localparam int IDX_W      = 4;
  localparam int NUM_BARS   = 6;
  localparam int BAR_FIRST  = 9;

  localparam int CTL_VFE = 0;
  localparam int CTL_MSE = 3;
  localparam int CTL_ARI = 4;

  localparam logic [31:0] PG_MINREQ = 32'h0000_0553;

  typedef enum logic [3:0] {
    DW_HDR   = 4'd0,
    DW_CAPS  = 4'd1,
    DW_CTRL  = 4'd2,
    DW_COUNT = 4'd3,
    DW_NUMVF = 4'd4,
    DW_ROUTE = 4'd5,
    DW_DEVID = 4'd6,
    DW_PGSUP = 4'd7,
    DW_PGSEL = 4'd8
  } dw_idx_e;

  // per-byte masked merge of write data into an old dword
  function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be,
                                           input logic [31:0] wmask);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[b*8 +: 8] = (old_v[b*8 +: 8] & ~wmask[b*8 +: 8]) |
                               (new_v[b*8 +: 8] &  wmask[b*8 +: 8]);
    end
    return r;
  endfunction

  function automatic bit is_mem64(input logic [3:0] ty);
    return (ty[0] == 1'b0) && (ty[2:1] == 2'b10);
  endfunction
endpackage

// File: rtl/vfcap_ctrl.sv
module vfcap_ctrl
  import vfcap_pkg::*;
#(
  parameter logic [15:0] TOTAL_VFS = 16'd8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic        wr_num,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [15:0] ctrl_q,
  output logic [15:0] numvf_q,
  output logic [15:0] active_vfs
);
  logic        lock_q;
  logic        vfe_wr_q;
  logic [31:0] ctrl_mask, num_mask;
  logic [31:0] ctrl_m, num_m;

  always_comb begin
    ctrl_mask = '0;
    ctrl_mask[CTL_VFE] = vfe_wr_q;
    ctrl_mask[CTL_MSE] = 1'b1;
    ctrl_mask[CTL_ARI] = 1'b1;
    num_mask = lock_q ? 32'h0 : 32'h0000_FFFF;
    ctrl_m = merge_be({16'h0, ctrl_q},  wdata, be, ctrl_mask);
    num_m  = merge_be({16'h0, numvf_q}, wdata, be, num_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      numvf_q    <= '0;
      lock_q     <= 1'b0;
      vfe_wr_q   <= 1'b1;
      active_vfs <= '0;
    end else begin
      active_vfs <= ctrl_q[CTL_VFE] ? numvf_q : '0;
      if (wr_ctrl) begin
        ctrl_q <= ctrl_m[15:0];
        if (be[0]) lock_q <= wdata[CTL_VFE];
      end
      if (wr_num) begin
        numvf_q <= num_m[15:0];
        if (|be[1:0]) vfe_wr_q <= (num_m[15:0] <= TOTAL_VFS);
      end
    end
  end

  assert_count_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(numvf_q));

  assert_enable_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !vfe_wr_q |=> !$rose(ctrl_q[CTL_VFE]));

  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CTL_VFE] |=> (active_vfs == '0));
endmodule

// File: rtl/vfcap_pgsel.sv
module vfcap_pgsel
  import vfcap_pkg::*;
#(
  parameter logic [31:0] SUP = PG_MINREQ
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] pg_q
);
  always_ff @(posedge clk) begin
    if (rst)        pg_q <= 32'h1;
    else if (wr_en) pg_q <= merge_be(pg_q, wdata, be, SUP);
  end

  assert_page_in_set_R6: assert property (@(posedge clk) disable iff (rst)
    (pg_q & ~SUP) == '0);
endmodule

// File: rtl/vfcap_bar.sv
module vfcap_bar
  import vfcap_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h0,
  parameter logic [31:0] WMASK   = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= merge_be(q, wdata, be, WMASK);
  end

  assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (q & ~WMASK) == (RST_VAL & ~WMASK));
endmodule

// File: rtl/vfcap_regfile.sv
module vfcap_regfile
  import vfcap_pkg::*;
#(
  parameter int                        ADDR_W      = 10,
  parameter logic [ADDR_W-1:0]         CAP_BASE    = 10'h040,
  parameter logic [11:0]               NEXT_PTR    = 12'h000,
  parameter logic [15:0]               TOTAL_VFS   = 16'd8,
  parameter logic [15:0]               INITIAL_VFS = 16'd4,
  parameter logic [15:0]               VF_OFFSET   = 16'd1,
  parameter logic [15:0]               VF_STRIDE   = 16'd1,
  parameter logic [15:0]               VF_DEVID    = 16'h10CA,
  parameter logic [31:0]               OPT_PGSZ    = 32'h0000_0004,
  parameter logic [NUM_BARS*4-1:0]     BAR_TYPES   = {4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
  parameter logic [NUM_BARS*64-1:0]    BAR_SIZES   = {64'd0, 64'd0, 64'd256, 64'd4096,
                                                      64'd0, 64'd16384}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic [15:0]       active_vfs,
  output logic [31:0]       sys_page_size
);
  localparam logic [ADDR_W:0] CAP_END = {1'b0, CAP_BASE} + (ADDR_W+1)'(CAP_DWORDS);
  localparam logic [31:0]     PG_SUP  = PG_MINREQ | OPT_PGSZ;

  logic             hit, wr_hit, rd_hit;
  logic [IDX_W-1:0] idx;
  logic [15:0]      ctrl_q, numvf_q;
  logic [31:0]      pg_q;
  logic [31:0]      bar_q [NUM_BARS];
  logic [31:0]      rd_n;

  assign hit    = acc_en && (acc_addr >= CAP_BASE) && ({1'b0, acc_addr} < CAP_END);
  assign idx    = acc_addr[IDX_W-1:0] - CAP_BASE[IDX_W-1:0];
  assign wr_hit = hit && acc_wr;
  assign rd_hit = hit && !acc_wr;

  vfcap_ctrl #(.TOTAL_VFS(TOTAL_VFS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (wr_hit && (idx == DW_CTRL)),
    .wr_num     (wr_hit && (idx == DW_NUMVF)),
    .be         (acc_be),
    .wdata      (acc_wdata),
    .ctrl_q     (ctrl_q),
    .numvf_q    (numvf_q),
    .active_vfs (active_vfs)
  );

  vfcap_pgsel #(.SUP(PG_SUP)) u_pgsel (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_hit && (idx == DW_PGSEL)),
    .be    (acc_be),
    .wdata (acc_wdata),
    .pg_q  (pg_q)
  );

  assign sys_page_size = pg_q;

  for (genvar j = 0; j < NUM_BARS; j++) begin : g_bar
    localparam int          PJ    = (j > 0) ? j - 1 : 0;
    localparam logic [3:0]  TY    = BAR_TYPES[j*4 +: 4];
    localparam logic [3:0]  PTY   = BAR_TYPES[PJ*4 +: 4];
    localparam logic [63:0] SZ    = BAR_SIZES[j*64 +: 64];
    localparam logic [63:0] PSZ   = BAR_SIZES[PJ*64 +: 64];
    localparam bit          UPPER = (j > 0) && is_mem64(PTY);
    localparam logic [63:0] NEG   = ~(SZ - 64'd1);
    localparam logic [63:0] PNEG  = ~(PSZ - 64'd1);
    localparam logic [31:0] WM    = UPPER ? PNEG[63:32] : NEG[31:0];
    localparam logic [31:0] RV    = UPPER ? 32'h0 : {28'h0, TY};

    initial begin
      assert_pow2_size_R7: assert ((SZ == 64'd0) || ((SZ & (SZ - 64'd1)) == 64'd0))
        else $error("BAR %0d aperture is not a power of two", j);
    end

    vfcap_bar #(.RST_VAL(RV), .WMASK(WM)) u_bar (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_hit && (idx == IDX_W'(BAR_FIRST + j))),
      .be    (acc_be),
      .wdata (acc_wdata),
      .q     (bar_q[j])
    );
  end

  always_comb begin
    rd_n = '0;
    case (idx)
      DW_HDR:   rd_n = {NEXT_PTR, 4'h1, 16'h0010};
      DW_CTRL:  rd_n = {16'h0, ctrl_q};
      DW_COUNT: rd_n = {TOTAL_VFS, INITIAL_VFS};
      DW_NUMVF: rd_n = {16'h0, numvf_q};
      DW_ROUTE: rd_n = {VF_STRIDE, VF_OFFSET};
      DW_DEVID: rd_n = {VF_DEVID, 16'h0};
      DW_PGSUP: rd_n = PG_SUP;
      DW_PGSEL: rd_n = pg_q;
      default: begin
        for (int j = 0; j < NUM_BARS; j++)
          if (idx == IDX_W'(BAR_FIRST + j)) rd_n = bar_q[j];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= rd_n;
    else             rd_data <= '0;
  end

  assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rd_data == '0));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && ((idx == DW_CAPS) || (idx == 4'd15))) |=> (rd_data == '0));
endmodule

// File: tb/vfcap_regfile_test.sv
module vfcap_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [9:0]  acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic [15:0] active_vfs;
  logic [31:0] sys_page_size;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R8";

  vfcap_regfile uut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .active_vfs(active_vfs), .sys_page_size(sys_page_size)
  );

  always #10 clk = ~clk;  // 50 MHz

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [16];
  bit          m_lock, m_vfewr;
  logic [31:0] m_rd;
  logic [15:0] m_act;

  function automatic logic [31:0] m_mask(input int i);
    case (i)
      2:  return {27'h0, 1'b1, 1'b1, 2'b00, m_vfewr};
      4:  return m_lock ? 32'h0 : 32'h0000_FFFF;
      8:  return 32'h557;
      9:  return 32'hFFFF_C000;
      10: return 32'hFFFF_FFFF;
      11: return 32'hFFFF_F000;
      12: return 32'hFFFF_FF00;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = 32'h0;
    m_reg[0] = 32'h0001_0010; m_reg[3] = 32'h0008_0004;
    m_reg[5] = 32'h0001_0001; m_reg[6] = 32'h10CA_0000;
    m_reg[7] = 32'h557;       m_reg[8] = 32'h1;
    m_reg[9] = 32'hC;         m_reg[12] = 32'h1;
    m_lock = 0; m_vfewr = 1; m_rd = 0; m_act = 0;
  endtask

  always @(posedge clk) begin
    if (rst) m_reset();
    else begin
      bit inwin;
      int i;
      logic [31:0] mk;
      inwin = acc_en && acc_addr >= 10'h40 && acc_addr < 10'h50;
      i = int'(acc_addr) - 'h40;
      m_act = m_reg[2][0] ? m_reg[4][15:0] : 16'h0;
      m_rd  = (inwin && !acc_wr) ? m_reg[i] : 32'h0;
      if (inwin && acc_wr) begin
        mk = m_mask(i);
        for (int b = 0; b < 4; b++)
          if (acc_be[b])
            for (int k = b*8; k < b*8+8; k++)
              if (mk[k]) m_reg[i][k] = acc_wdata[k];
        if (i == 2 && acc_be[0]) m_lock = acc_wdata[0];
        if (i == 4 && (acc_be[0] || acc_be[1])) m_vfewr = (m_reg[4][15:0] <= 16'd8);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    cyc++;
    #2;
    if (cyc > 1) begin
      check({cur_req, " rd_data"}, rd_data, m_rd);
      check({cur_req, " active_vfs"}, {16'h0, active_vfs}, {16'h0, m_act});
      check({cur_req, " sys_page_size"}, sys_page_size, m_reg[8]);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_be = 4'h0;
    @(posedge clk); #2;
    check(req, rd_data, exp);
    @(negedge clk);
    acc_en = 0;
  endtask

  task automatic act_chk(input logic [15:0] exp, input string req);
    @(negedge clk); @(negedge clk);
    check(req, {16'h0, active_vfs}, {16'h0, exp});
  endtask

  localparam logic [9:0] B = 10'h40;

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R8";
    for (int i = 0; i < 16; i++) rd_chk(B + 10'(i), m_reg[i], "R8 reset image");
    rd_chk(B + 0, 32'h0001_0010, "R9 header");
    rd_chk(B + 1, 32'h0, "R9 reserved dword");
    rd_chk(B + 12, 32'h1, "R7 io bar reset type");

    cur_req = "R1";
    wr(B - 1, 4'hF, 32'hFFFF_FFFF);
    wr(B + 16, 4'hF, 32'hFFFF_FFFF);
    rd_chk(B - 1, 32'h0, "R1 below window");
    rd_chk(B + 16, 32'h0, "R1 past window");
    rd_chk(B + 8, 32'h1, "R1 page size untouched");

    cur_req = "R6";
    wr(B + 8, 4'hF, 32'hFFFF_FFFF);
    rd_chk(B + 8, 32'h557, "R6 page size mask");
    cur_req = "R2";
    wr(B + 8, 4'h1, 32'h0);
    rd_chk(B + 8, 32'h500, "R2 single lane");

    cur_req = "R4";
    wr(B + 4, 4'h3, 32'h5);
    wr(B + 2, 4'h1, 32'h19);
    rd_chk(B + 2, 32'h19, "R3 control set");
    act_chk(16'd5, "R5 active count");
    wr(B + 4, 4'h3, 32'h3);
    rd_chk(B + 4, 32'h5, "R4 count locked");

    cur_req = "R3";
    wr(B + 2, 4'h1, 32'h18);
    act_chk(16'd0, "R5 disabled");
    wr(B + 4, 4'h3, 32'h9);
    rd_chk(B + 4, 32'h9, "R4 count unlocked");
    wr(B + 2, 4'h1, 32'h19);
    rd_chk(B + 2, 32'h18, "R3 enable blocked");
    wr(B + 4, 4'h3, 32'h2);
    rd_chk(B + 4, 32'h9, "R4 lock from blocked write");
    wr(B + 2, 4'h1, 32'h0);
    wr(B + 4, 4'h3, 32'h2);
    wr(B + 2, 4'h1, 32'h1);
    rd_chk(B + 2, 32'h1, "R3 enable allowed");
    act_chk(16'd2, "R5 active two");
    cur_req = "R2";
    wr(B + 2, 4'h2, 32'hFFFF_FFFF);
    rd_chk(B + 2, 32'h1, "R2 control lane1");
    wr(B + 2, 4'h1, 32'h0);
    wr(B + 4, 4'h2, 32'h0000_0300);
    rd_chk(B + 4, 32'h302, "R2 count high lane");
    cur_req = "R3";
    wr(B + 2, 4'h1, 32'h19);
    rd_chk(B + 2, 32'h18, "R3 blocked after high lane");

    cur_req = "R7";
    for (int j = 9; j < 15; j++) wr(B + 10'(j), 4'hF, 32'hFFFF_FFFF);
    rd_chk(B + 9,  32'hFFFF_C00C, "R7 bar64 low");
    rd_chk(B + 10, 32'hFFFF_FFFF, "R7 bar64 high");
    rd_chk(B + 11, 32'hFFFF_F000, "R7 bar32");
    rd_chk(B + 12, 32'hFFFF_FF01, "R7 io bar");
    rd_chk(B + 13, 32'h0, "R7 unused bar");
    rd_chk(B + 14, 32'h0, "R7 unused bar");
    cur_req = "R2";
    wr(B + 9, 4'h8, 32'h1200_0000);
    rd_chk(B + 9, 32'h12FF_C00C, "R2 bar top lane");

    cur_req = "R8";
    wr(B + 3, 4'hF, 32'hFFFF_FFFF);
    wr(B + 5, 4'hF, 32'h0);
    wr(B + 6, 4'hF, 32'h0);
    wr(B + 7, 4'hF, 32'h0);
    rd_chk(B + 3, 32'h0008_0004, "R8 counts fixed");
    rd_chk(B + 5, 32'h0001_0001, "R8 routing fixed");
    rd_chk(B + 6, 32'h10CA_0000, "R8 device id fixed");
    rd_chk(B + 7, 32'h557, "R6 supported fixed");

    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd_chk(B + 2, 32'h0, "R8 control after reset");
    rd_chk(B + 4, 32'h0, "R8 count after reset");
    rd_chk(B + 8, 32'h1, "R6 page after reset");
    rd_chk(B + 9, 32'hC, "R7 bar after reset");
    rd_chk(B + 10, 32'h0, "R7 upper half after reset");
    wr(B + 4, 4'h3, 32'h4);
    wr(B + 2, 4'h1, 32'h1);
    act_chk(16'd4, "R4 lock cleared by reset");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule